// File: doc/BRIEF.md
# Page-One Stack Call/Return Sequencer

This block performs the stack traffic of an 8-bit processor's control-transfer instructions: subroutine call, subroutine return, software interrupt and return from interrupt. It owns the 8-bit stack pointer S. The stack always sits in memory page one, at address 0x0100 + S. Fetch and decode stay outside the block. The controlling logic pulses `start` with an operation code, the current program counter, the status byte and a target address. The sequencer then drives a byte-wide memory port with exactly one access per clock and reports the new program counter and status with a one-cycle `done` pulse.

Memory reads are taken as combinational. `mem_rdata` must answer the `mem_addr` of the same cycle, and the block captures it at the end of that cycle. A new operation may be started in the same cycle as the `done` pulse of the previous one. The block ignores a start that arrives while an operation is still running.

Top module: `stack_seq`

## Requirements
- R1: A push writes address 0x0100 + S and S then drops by one. A pull first raises S by one and then reads 0x0100 + S. S wraps modulo 256 and every stack access stays in page one. `sp_out` shows S at all times.
- R2: Operation code 0 (call) writes the high byte and then the low byte of `pc_in` − 1, with the borrow carried across bytes. It then reports `target` as the new PC.
- R3: Operation code 1 (return) pulls the low byte and then the high byte. The new PC is the assembled 16-bit value plus one, modulo 65536.
- R4: Operation code 2 (software interrupt) pushes PC high, PC low and then `p_in` unchanged. It then reads 0xFFFE as the low byte and 0xFFFF as the high byte of the new PC, and reports `p_in` with bit 2 (interrupt disable) set.
- R5: Operation code 3 (return from interrupt) pulls the status byte, then PC low, then PC high. It reports the pulled status byte unchanged and the assembled PC with no increment.
- R6: Accesses begin in the cycle after `start` is accepted and occur in consecutive cycles, one per clock. `mem_we` is high exactly in push cycles and low whenever the block is idle.
- R7: `done` is high for exactly one cycle, the cycle after the final access. `pc_out` and `p_out` take their new values in that cycle and hold them until the next `done`. Call and return report `p_in` as `p_out`.
- R8: A `start` that arrives while an operation is in progress has no effect. A `start` in the `done` cycle is accepted.
- R9: After reset S is 0xFF, `pc_out` and `p_out` are zero, and `done` and `mem_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin an operation |
| op | input | 2 | Operation code: 0 call, 1 return, 2 software interrupt, 3 return from interrupt |
| pc_in | input | 16 | Address of the next instruction |
| p_in | input | 8 | Current status byte |
| target | input | 16 | Call destination |
| mem_rdata | input | 8 | Read data for the current `mem_addr` (combinational) |
| mem_addr | output | 16 | Memory address for this cycle |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Write enable |
| pc_out | output | 16 | Resulting program counter |
| p_out | output | 8 | Resulting status byte |
| sp_out | output | 8 | Current stack pointer |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two events can fall in the same cycle: the completion pulse of one operation and the acceptance of the next `start`. The reverse case can also occur, where a new `start` lands while the sequencer is mid-operation. The bench provokes both. It issues operations back to back with no idle gap, and it raises `start` with different operands in the middle of a running operation. A cycle-by-cycle reference model judges the result. The model expects the first access of the new operation in the cycle right after `done`. It expects the access stream of an interrupted operation to continue unchanged, and the stray request must leave no trace on the memory port or the results.

// File: rtl/stk_pkg.sv
package stk_pkg;

  typedef enum logic [1:0] {
    OP_CALL = 2'd0,
    OP_RET  = 2'd1,
    OP_BRK  = 2'd2,
    OP_RTI  = 2'd3
  } stk_op_e;

  typedef enum logic [1:0] {
    CAP_NONE = 2'd0,
    CAP_LO   = 2'd1,
    CAP_HI   = 2'd2,
    CAP_P    = 2'd3
  } cap_e;

  localparam int STEP_W    = 3;
  localparam int IFLAG_BIT = 2;

  // number of memory accesses per operation
  function automatic logic [STEP_W-1:0] op_len(stk_op_e op);
    case (op)
      OP_CALL: return STEP_W'(2);
      OP_RET:  return STEP_W'(2);
      OP_BRK:  return STEP_W'(5);
      default: return STEP_W'(3);
    endcase
  endfunction

  // value a subroutine call leaves on the stack
  function automatic logic [15:0] call_link(logic [15:0] pc);
    return pc - 16'd1;
  endfunction

  // PC after a subroutine return
  function automatic logic [15:0] rts_pc(logic [7:0] hi, logic [7:0] lo);
    return {hi, lo} + 16'd1;
  endfunction

  // status after a software interrupt
  function automatic logic [7:0] brk_status(logic [7:0] p);
    return p | (8'd1 << IFLAG_BIT);
  endfunction

endpackage

// File: rtl/stk_sequencer.sv
module stk_sequencer
  import stk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  stk_op_e           op_in,
  output logic              busy,
  output logic [STEP_W-1:0] step,
  output stk_op_e           cur_op,
  output logic              accept,
  output logic              last,
  output logic              done
);

  assign accept = start & ~busy;
  assign last   = busy && (step == op_len(cur_op) - STEP_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      step   <= '0;
      cur_op <= OP_CALL;
      done   <= 1'b0;
    end else begin
      done <= last;
      if (accept) begin
        busy   <= 1'b1;
        step   <= '0;
        cur_op <= op_in;
      end else if (last) begin
        busy <= 1'b0;
      end else if (busy) begin
        step <= step + STEP_W'(1);
      end
    end
  end

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> (busy && $stable(cur_op)));

endmodule

// File: rtl/stk_access_decode.sv
module stk_access_decode
  import stk_pkg::*;
#(
  parameter logic [7:0]  STACK_PAGE = 8'h01,
  parameter logic [15:0] VECTOR_LO  = 16'hFFFE
) (
  input  logic              busy,
  input  stk_op_e           cur_op,
  input  logic [STEP_W-1:0] step,
  input  logic [7:0]        sp,
  input  logic [15:0]       pc_l,
  input  logic [7:0]        p_l,
  output logic [15:0]       addr,
  output logic [7:0]        wdata,
  output logic              we,
  output logic [7:0]        sp_nx,
  output cap_e              cap,
  output logic              is_vec
);

  logic [15:0] link;
  logic [15:0] push_a;
  logic [15:0] pull_a;

  assign link   = call_link(pc_l);
  assign push_a = {STACK_PAGE, sp};
  assign pull_a = {STACK_PAGE, sp + 8'd1};

  always_comb begin
    addr   = '0;
    wdata  = '0;
    we     = 1'b0;
    sp_nx  = sp;
    cap    = CAP_NONE;
    is_vec = 1'b0;
    if (busy) begin
      case (cur_op)
        OP_CALL: begin
          we    = 1'b1;
          addr  = push_a;
          sp_nx = sp - 8'd1;
          wdata = (step == '0) ? link[15:8] : link[7:0];
        end
        OP_RET: begin
          addr  = pull_a;
          sp_nx = sp + 8'd1;
          cap   = (step == '0) ? CAP_LO : CAP_HI;
        end
        OP_BRK: begin
          if (step < STEP_W'(3)) begin
            we    = 1'b1;
            addr  = push_a;
            sp_nx = sp - 8'd1;
            case (step)
              STEP_W'(0): wdata = pc_l[15:8];
              STEP_W'(1): wdata = pc_l[7:0];
              default:    wdata = p_l;
            endcase
          end else begin
            is_vec = 1'b1;
            addr   = (step == STEP_W'(3)) ? VECTOR_LO : VECTOR_LO + 16'd1;
            cap    = (step == STEP_W'(3)) ? CAP_LO : CAP_HI;
          end
        end
        default: begin
          addr  = pull_a;
          sp_nx = sp + 8'd1;
          case (step)
            STEP_W'(0): cap = CAP_P;
            STEP_W'(1): cap = CAP_LO;
            default:    cap = CAP_HI;
          endcase
        end
      endcase
    end
  end

endmodule

// File: rtl/stack_seq.sv
module stack_seq
  import stk_pkg::*;
#(
  parameter logic [7:0]  SP_RESET   = 8'hFF,
  parameter logic [7:0]  STACK_PAGE = 8'h01,
  parameter logic [15:0] VECTOR_LO  = 16'hFFFE
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [1:0]  op,
  input  logic [15:0] pc_in,
  input  logic [7:0]  p_in,
  input  logic [15:0] target,
  input  logic [7:0]  mem_rdata,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  output logic        mem_we,
  output logic [15:0] pc_out,
  output logic [7:0]  p_out,
  output logic [7:0]  sp_out,
  output logic        done
);

  logic              busy, accept, last, is_vec;
  logic [STEP_W-1:0] step;
  stk_op_e           cur_op;
  cap_e              cap;
  logic [7:0]        sp, sp_nx, p_l, lo_buf, p_pull;
  logic [15:0]       pc_l, tgt_l;

  // named events for the checks
  logic push_ev, pull_ev, fin_brk;
  assign push_ev = mem_we;
  assign pull_ev = busy & ~mem_we & ~is_vec;
  assign fin_brk = last & (cur_op == OP_BRK);

  stk_sequencer u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .op_in  (stk_op_e'(op)),
    .busy   (busy),
    .step   (step),
    .cur_op (cur_op),
    .accept (accept),
    .last   (last),
    .done   (done)
  );

  stk_access_decode #(
    .STACK_PAGE (STACK_PAGE),
    .VECTOR_LO  (VECTOR_LO)
  ) u_dec (
    .busy   (busy),
    .cur_op (cur_op),
    .step   (step),
    .sp     (sp),
    .pc_l   (pc_l),
    .p_l    (p_l),
    .addr   (mem_addr),
    .wdata  (mem_wdata),
    .we     (mem_we),
    .sp_nx  (sp_nx),
    .cap    (cap),
    .is_vec (is_vec)
  );

  assign sp_out = sp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp     <= SP_RESET;
      pc_l   <= '0;
      p_l    <= '0;
      tgt_l  <= '0;
      lo_buf <= '0;
      p_pull <= '0;
      pc_out <= '0;
      p_out  <= '0;
    end else begin
      sp <= sp_nx;
      if (accept) begin
        pc_l  <= pc_in;
        p_l   <= p_in;
        tgt_l <= target;
      end
      if (cap == CAP_LO) lo_buf <= mem_rdata;
      if (cap == CAP_P)  p_pull <= mem_rdata;
      if (last) begin
        case (cur_op)
          OP_CALL: begin pc_out <= tgt_l;                     p_out <= p_l;             end
          OP_RET:  begin pc_out <= rts_pc(mem_rdata, lo_buf); p_out <= p_l;             end
          OP_BRK:  begin pc_out <= {mem_rdata, lo_buf};       p_out <= brk_status(p_l); end
          default: begin pc_out <= {mem_rdata, lo_buf};       p_out <= p_pull;          end
        endcase
      end
    end
  end

  // R1
  push_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_ev |=> sp_out == $past(sp_out) - 8'd1);

  // R1
  pull_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pull_ev |=> sp_out == $past(sp_out) + 8'd1);

  // R1
  page_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !is_vec) |-> mem_addr[15:8] == STACK_PAGE);

  // R1
  idle_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> sp_out == $past(sp_out));

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_we);

  // R4
  brk_iflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin_brk |=> p_out[IFLAG_BIT]);

  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !last |=> ($stable(pc_out) && $stable(p_out)));

endmodule

// File: tb/stack_seq_test.sv
module stack_seq_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = 2'd0;
  logic [15:0] pc_in = '0;
  logic [7:0]  p_in = '0;
  logic [15:0] target = '0;
  logic [7:0]  mem_rdata;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_we;
  logic [15:0] pc_out;
  logic [7:0]  p_out;
  logic [7:0]  sp_out;
  logic        done;

  int n_chk = 0;
  int n_fail = 0;

  logic [7:0] stk [256];
  logic [7:0] ref_stk [256];
  logic [7:0] vlo = 8'h34;
  logic [7:0] vhi = 8'hE1;
  int sp_m;
  logic [24:0] exp_q [$];

  always #2 clk = ~clk;

  stack_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .pc_in(pc_in),
    .p_in(p_in), .target(target), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .pc_out(pc_out), .p_out(p_out), .sp_out(sp_out), .done(done)
  );

  assign mem_rdata = (mem_addr == 16'hFFFE) ? vlo :
                     (mem_addr == 16'hFFFF) ? vhi : stk[mem_addr[7:0]];

  always @(posedge clk)
    if (mem_we && mem_addr[15:8] == 8'h01) stk[mem_addr[7:0]] <= mem_wdata;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic m_push(input logic [7:0] v);
    exp_q.push_back({1'b1, 8'h01, sp_m[7:0], v});
    ref_stk[sp_m] = v;
    sp_m = (sp_m - 1) & 255;
  endtask

  task automatic m_pull(output logic [7:0] v);
    sp_m = (sp_m + 1) & 255;
    exp_q.push_back({1'b0, 8'h01, sp_m[7:0], 8'h00});
    v = ref_stk[sp_m];
  endtask

  // called at a negedge; returns at the negedge of the done cycle
  task automatic run_op(input logic [1:0] o, input logic [15:0] pc,
                        input logic [7:0] p, input logic [15:0] tgt,
                        input bit poke);
    logic [15:0] pc_e, link;
    logic [7:0]  p_e, lo, hi, ps;
    string req;
    exp_q.delete();
    case (o)
      2'd0: begin
        req = "R2"; link = pc - 16'd1;
        m_push(link[15:8]); m_push(link[7:0]);
        pc_e = tgt; p_e = p;
      end
      2'd1: begin
        req = "R3"; m_pull(lo); m_pull(hi);
        pc_e = {hi, lo} + 16'd1; p_e = p;
      end
      2'd2: begin
        req = "R4";
        m_push(pc[15:8]); m_push(pc[7:0]); m_push(p);
        exp_q.push_back({1'b0, 16'hFFFE, 8'h00});
        exp_q.push_back({1'b0, 16'hFFFF, 8'h00});
        pc_e = {vhi, vlo}; p_e = p | 8'h04;
      end
      default: begin
        req = "R5"; m_pull(ps); m_pull(lo); m_pull(hi);
        pc_e = {hi, lo}; p_e = ps;
      end
    endcase
    start = 1'b1; op = o; pc_in = pc; p_in = p; target = tgt;
    @(posedge clk);
    for (int k = 0; k < exp_q.size(); k++) begin
      @(negedge clk);
      start = 1'b0;
      if (poke && k == 1) begin
        // R8: a request while busy must leave no trace
        start = 1'b1; op = o + 2'd1; pc_in = ~pc; p_in = ~p; target = ~tgt;
      end
      chk(mem_we == exp_q[k][24], "R6", "write enable", mem_we, exp_q[k][24]);
      chk(mem_addr == exp_q[k][23:8], req, "address", mem_addr, exp_q[k][23:8]);
      if (exp_q[k][24])
        chk(mem_wdata == exp_q[k][7:0], req, "write data", mem_wdata, exp_q[k][7:0]);
      chk(done == 1'b0, "R7", "done early", done, 0);
    end
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b1, "R7", "done pulse", done, 1);
    chk(pc_out == pc_e, req, "pc_out", pc_out, pc_e);
    chk(p_out == p_e, (o < 2) ? "R7" : req, "p_out", p_out, p_e);
    chk(sp_out == sp_m[7:0], "R1", "sp_out", sp_out, sp_m);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(mem_we == 1'b0 && done == 1'b0, "R6", "idle quiet", {mem_we, done}, 0);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      stk[i] = 8'((i * 7 + 3) & 255);
      ref_stk[i] = 8'((i * 7 + 3) & 255);
    end
    sp_m = 255;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(sp_out == 8'hFF, "R9", "reset sp", sp_out, 8'hFF);
    chk(pc_out == 16'h0 && p_out == 8'h0, "R9", "reset outputs", {pc_out, p_out}, 0);
    chk(done == 1'b0 && mem_we == 1'b0, "R9", "reset done/we", {done, mem_we}, 0);
    idle(2);

    run_op(2'd0, 16'h1234, 8'h21, 16'hC000, 1'b0);  // R2
    idle(1);
    run_op(2'd1, 16'h5555, 8'h42, 16'h0000, 1'b0);  // R3 -> 0x1234
    run_op(2'd0, 16'h1200, 8'h00, 16'h8000, 1'b0);  // R2 borrow
    run_op(2'd1, 16'h0000, 8'h00, 16'h0000, 1'b0);  // R3 carry
    run_op(2'd2, 16'h2345, 8'h81, 16'h0000, 1'b0);  // R4
    run_op(2'd3, 16'h0000, 8'h00, 16'h0000, 1'b0);  // R5 restores 0x81
    run_op(2'd2, 16'hFFFF, 8'h04, 16'h0000, 1'b1);  // R4 I already set, R8 poke
    idle(1);
    run_op(2'd3, 16'h0000, 8'h00, 16'h0000, 1'b1);  // R5, R8 poke

    // R1 wrap: deep pushes then pulls across the 0x00/0xFF boundary
    for (int i = 0; i < 140; i++)
      run_op(2'd0, 16'(i * 257 + 1), 8'h10, 16'(i), 1'b0);
    for (int i = 0; i < 140; i++)
      run_op(2'd1, 16'h0, 8'h10, 16'h0, i[0]);

    for (int i = 0; i < 500; i++) begin
      vlo = 8'($urandom); vhi = 8'($urandom);
      run_op(2'($urandom), 16'($urandom), 8'($urandom), 16'($urandom),
             ($urandom % 4) == 0);
      idle($urandom % 3);
    end
    idle(2);
    summary();
  end

endmodule